// File: doc/BRIEF.md
# Bidirectional Trail Code Direction Detector

This block has two independent halves that share one clock and one synchronous reset. The first half is a generator. It lays a repeating six-bit trail code, one bit per clock cycle. The code is the cyclic sequence 1,0,0,1,1,0. When the parameter `INVERT` is set, it emits the bitwise complement instead.

The second half is a serial detector. It takes a received bit stream with a valid strobe and keeps the five most recent accepted bits. From those five bits it reports whether the stream is being read in the order the code was laid or in the opposite order. The code is built so that no five-bit stretch read forwards equals any five-bit stretch read backwards. Because of this, a reader that starts at any of the six phases can settle the direction from a single short window and needs no framing marker. A window that belongs to neither set raises an error flag for as long as it is present.

The generator is a six-state phase machine with states PH0 to PH5:
- Reset places it in PH0.
- Each clock it steps PH0→PH1→PH2→PH3→PH4→PH5.
- From PH5 it wraps back to PH0.

The detector is a two-state machine:
- W_FILL counts accepted bits.
- On the accepted bit that brings the count to five, it takes the transition fill-to-full into W_FULL.
- W_FULL persists until reset.

Top module: `trail_dir_detect`

## Requirements
- R1: After reset the generator output follows the phases PH0..PH5 as 1,0,0,1,1,0 and wraps from PH5 to PH0, so the seventh bit is 1 again.
- R2: With `INVERT`=1 the generator emits the complement sequence 0,1,1,0,0,1 from PH0.
- R3: `decided` is 0 from reset until five bits have been accepted with `in_valid`=1, and it rises right after the clock edge that accepts the fifth bit. While `decided` is 0, `dir_fwd`, `dir_rev` and `code_err` are all 0.
- R4: A cycle with `in_valid`=0 neither shifts the window nor advances the count of accepted bits.
- R5: Windows are written oldest bit first. With `INVERT`=0, windows 10011, 00110, 01101, 11010, 10100 and 01001 give `dir_fwd`=1, `dir_rev`=0, `code_err`=0.
- R6: With `INVERT`=0, windows 01100, 11001, 10010, 00101, 01011 and 10110 give `dir_rev`=1, `dir_fwd`=0, `code_err`=0.
- R7: Once decided, a window in neither set (for example 00000, 11111 or 10101) gives `code_err`=1 with both direction flags 0.
- R8: After `decided` is high, every further accepted bit reclassifies the latest five bits within the same cycle's update.
- R9: Once decided, exactly one of `dir_fwd`, `dir_rev` and `code_err` is 1, and `decided` stays 1 until reset.
- R10: With `INVERT`=1 both window sets are complemented: 01100 reads as forward and 10011 reads as reverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gen_bit | output | 1 | Trail code bit for the current phase |
| in_bit | input | 1 | Received trail bit |
| in_valid | input | 1 | Accept `in_bit` at this clock edge |
| dir_fwd | output | 1 | Window is read in the laying direction |
| dir_rev | output | 1 | Window is read against the laying direction |
| decided | output | 1 | Five bits have been accepted since reset |
| code_err | output | 1 | Window matches neither direction set |

## Verification
The outputs decode registered state combinationally, so there are no pipeline stages to account for:
- The generator bit for PH0 is visible as soon as reset is released.
- The generator bit for each later phase is visible after the following rising edge.
- All four detector flags reflect an accepted bit right after the edge that shifts it in.

The bench drives inputs on the falling edge and samples 1 ns after the rising edge that should produce the result. For the detector this is the edge of the fifth accepted bit, or of each later bit when checking the sliding window. No check looks at a cycle in between.

// File: rtl/trail_pkg.sv
package trail_pkg;
    localparam int PERIOD = 6;
    localparam int WIN    = 5;
    localparam logic [PERIOD-1:0] BASE_CODE = 6'b011001; // bit i = phase i

    typedef enum logic [2:0] {PH0, PH1, PH2, PH3, PH4, PH5} phase_e;
    typedef enum logic {W_FILL, W_FULL} win_state_e;

    // Window seen when reading forwards from phase p, oldest bit in MSB
    function automatic logic [WIN-1:0] fwd_window(input logic [PERIOD-1:0] code, input int p);
        logic [WIN-1:0] w;
        w = '0;
        for (int k = 0; k < WIN; k++) begin
            w[WIN-1-k] = code[(p + k) % PERIOD];
        end
        return w;
    endfunction

    // Window seen when reading backwards from phase p, oldest bit in MSB
    function automatic logic [WIN-1:0] rev_window(input logic [PERIOD-1:0] code, input int p);
        logic [WIN-1:0] w;
        w = '0;
        for (int k = 0; k < WIN; k++) begin
            w[WIN-1-k] = code[(p - k + PERIOD) % PERIOD];
        end
        return w;
    endfunction
endpackage

// File: rtl/trail_gen.sv
module trail_gen
    import trail_pkg::*;
#(
    parameter logic [PERIOD-1:0] CODE = BASE_CODE
) (
    input  logic clk,
    input  logic rst,
    output logic gen_bit
);
    phase_e phase_q;
    phase_e phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH0;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d = PH0;
        unique case (phase_q)
            PH0: phase_d = PH1;
            PH1: phase_d = PH2;
            PH2: phase_d = PH3;
            PH3: phase_d = PH4;
            PH4: phase_d = PH5;
            PH5: phase_d = PH0;
            default: phase_d = PH0;
        endcase
    end

    always_comb begin
        gen_bit = CODE[int'(phase_q)];
    end

    // R1: PH5 wraps to PH0
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH5) |=> (phase_q == PH0));
    // R1: the phase always advances
    a_r1_advance: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH5) |=> (int'(phase_q) == int'($past(phase_q)) + 1));
endmodule

// File: rtl/trail_window.sv
module trail_window
    import trail_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_bit,
    input  logic           in_valid,
    output logic [WIN-1:0] window,
    output logic           full
);
    localparam int CW = $clog2(WIN);

    win_state_e     state_q;
    win_state_e     state_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_d;
    logic [WIN-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_FILL;
            cnt_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (in_valid) win_q <= {win_q[WIN-2:0], in_bit};
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            W_FILL: begin
                if (in_valid) begin
                    if (cnt_q == CW'(WIN - 1)) state_d = W_FULL;
                    else                        cnt_d   = cnt_q + 1'b1;
                end
            end
            W_FULL: state_d = W_FULL;
            default: state_d = W_FILL;
        endcase
    end

    always_comb begin
        window = win_q;
        full   = (state_q == W_FULL);
    end

    // R4: a cycle without valid leaves the window untouched
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(win_q));
    // R4: a cycle without valid leaves the count untouched
    a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && state_q == W_FILL) |=> (state_q == W_FILL && $stable(cnt_q)));
    // R3: the count stays below the window length while filling
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        (state_q == W_FILL) |-> (int'(cnt_q) < WIN));
endmodule

// File: rtl/trail_classify.sv
module trail_classify
    import trail_pkg::*;
#(
    parameter logic [PERIOD-1:0] CODE = BASE_CODE
) (
    input  logic [WIN-1:0] window,
    output logic           hit_fwd,
    output logic           hit_rev
);
    logic [PERIOD-1:0] fwd_match;
    logic [PERIOD-1:0] rev_match;

    for (genvar p = 0; p < PERIOD; p++) begin : g_phase
        localparam logic [WIN-1:0] FWD_W = fwd_window(CODE, p);
        localparam logic [WIN-1:0] REV_W = rev_window(CODE, p);
        assign fwd_match[p] = (window == FWD_W);
        assign rev_match[p] = (window == REV_W);
    end

    always_comb begin
        hit_fwd = |fwd_match;
        hit_rev = |rev_match;
    end

    // R9: the code keeps the two window sets apart
    always_comb begin
        a_r9_disjoint: assert (!(hit_fwd && hit_rev));
    end
endmodule

// File: rtl/trail_dir_detect.sv
module trail_dir_detect
    import trail_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    output logic gen_bit,
    input  logic in_bit,
    input  logic in_valid,
    output logic dir_fwd,
    output logic dir_rev,
    output logic decided,
    output logic code_err
);
    localparam logic [PERIOD-1:0] CODE = INVERT ? ~BASE_CODE : BASE_CODE;

    logic [WIN-1:0] window;
    logic           full;
    logic           hit_fwd;
    logic           hit_rev;

    trail_gen #(.CODE(CODE)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .gen_bit (gen_bit)
    );

    trail_window u_win (
        .clk      (clk),
        .rst      (rst),
        .in_bit   (in_bit),
        .in_valid (in_valid),
        .window   (window),
        .full     (full)
    );

    trail_classify #(.CODE(CODE)) u_cls (
        .window  (window),
        .hit_fwd (hit_fwd),
        .hit_rev (hit_rev)
    );

    always_comb begin
        decided  = full;
        dir_fwd  = full && hit_fwd;
        dir_rev  = full && hit_rev;
        code_err = full && !hit_fwd && !hit_rev;
    end

    // R9: exactly one flag while decided
    a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
        decided |-> ($countones({dir_fwd, dir_rev, code_err}) == 1));
    // R9: decided holds until reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        decided |=> decided);
    // R3: flags quiet before a decision
    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        !decided |-> !(dir_fwd || dir_rev || code_err));
endmodule

// File: tb/trail_dir_detect_bench.sv
`timescale 1ns/1ps
module trail_dir_detect_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_bit = 1'b0;
    logic in_valid = 1'b0;
    logic gen_bit, dir_fwd, dir_rev, decided, code_err;
    logic gen_i, fwd_i, rev_i, dec_i, err_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    trail_dir_detect u_trail_dir_detect (
        .clk(clk), .rst(rst), .gen_bit(gen_bit), .in_bit(in_bit), .in_valid(in_valid),
        .dir_fwd(dir_fwd), .dir_rev(dir_rev), .decided(decided), .code_err(code_err));

    trail_dir_detect #(.INVERT(1'b1)) u_inv (
        .clk(clk), .rst(rst), .gen_bit(gen_i), .in_bit(in_bit), .in_valid(in_valid),
        .dir_fwd(fwd_i), .dir_rev(rev_i), .decided(dec_i), .code_err(err_i));

    // window (oldest bit first) and expected result: 1 fwd, 2 rev, 3 err
    typedef struct packed { logic [4:0] w; logic [1:0] exp; } vec_t;
    localparam vec_t VECS [15] = '{
        '{5'b10011, 2'd1}, '{5'b00110, 2'd1}, '{5'b01101, 2'd1},
        '{5'b11010, 2'd1}, '{5'b10100, 2'd1}, '{5'b01001, 2'd1},
        '{5'b01100, 2'd2}, '{5'b11001, 2'd2}, '{5'b10010, 2'd2},
        '{5'b00101, 2'd2}, '{5'b01011, 2'd2}, '{5'b10110, 2'd2},
        '{5'b00000, 2'd3}, '{5'b11111, 2'd3}, '{5'b10101, 2'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic b, input logic v);
        @(negedge clk);
        in_bit = b; in_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic push_word(input logic [4:0] w);
        for (int k = 4; k >= 0; k--) push(w[k], 1'b1);
    endtask

    function automatic int flags();
        return {dir_fwd, dir_rev, code_err};
    endfunction

    initial begin
        int exp_flags;
        logic [5:0] seq;
        seq = 6'b100110; // MSB = PH0

        // Reset state and generator sequence
        do_reset();
        #1;
        check(decided == 1'b0 && flags() == 0, "R3", {decided, flags()}, 0);
        check(gen_bit == 1'b1, "R1", gen_bit, 1);
        check(gen_i == 1'b0, "R2", gen_i, 0);
        for (int i = 1; i < 7; i++) begin
            @(posedge clk); #1;
            check(gen_bit == seq[5 - (i % 6)], "R1", gen_bit, seq[5 - (i % 6)]);
            check(gen_i == !seq[5 - (i % 6)], "R2", gen_i, !seq[5 - (i % 6)]);
        end

        // Vector table: every phase, both directions, invalid windows
        for (int v = 0; v < 15; v++) begin
            do_reset();
            for (int k = 4; k >= 1; k--) push(VECS[v].w[k], 1'b1);
            check(decided == 1'b0, "R3", decided, 0);
            push(VECS[v].w[0], 1'b1);
            exp_flags = (VECS[v].exp == 2'd1) ? 4 : (VECS[v].exp == 2'd2) ? 2 : 1;
            check(decided == 1'b1, "R3", decided, 1);
            if (VECS[v].exp == 2'd1)      check(flags() == exp_flags, "R5", flags(), exp_flags);
            else if (VECS[v].exp == 2'd2) check(flags() == exp_flags, "R6", flags(), exp_flags);
            else                          check(flags() == exp_flags, "R7", flags(), exp_flags);
        end

        // R4: idle cycles neither shift nor count
        do_reset();
        push(1, 1); push(0, 1); push(0, 1); push(1, 1);
        push(0, 0); push(1, 0); push(0, 0);
        check(decided == 1'b0, "R4", decided, 0);
        push(1, 1);
        check(decided == 1'b1 && flags() == 4, "R4", flags(), 4);
        push(0, 0); push(0, 0);
        check(flags() == 4, "R4", flags(), 4);

        // R8: sliding reclassification after decision
        push(0, 1); // 00110
        check(flags() == 4, "R8", flags(), 4);
        push(0, 1); // 01100
        check(flags() == 2, "R8", flags(), 2);
        push(0, 1); // 11000
        check(flags() == 1 && decided, "R8", flags(), 1);

        // R10: inverted code sets
        do_reset();
        push_word(5'b01100);
        check(fwd_i && !rev_i && !err_i, "R10", {fwd_i, rev_i, err_i}, 4);
        do_reset();
        push_word(5'b10011);
        check(!fwd_i && rev_i && !err_i, "R10", {fwd_i, rev_i, err_i}, 2);

        // R9: reset clears a decision
        do_reset();
        #1;
        check(decided == 1'b0 && flags() == 0, "R9", decided, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule